// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between the load/store stage of a 32-bit processor and a 32-bit data bus that addresses individual bytes. For each request it takes a byte address, an access size (byte, half-word or word), a signedness flag and, on stores, the register value. On a store it moves the value into the byte lanes the address points at and raises one select bit for each lane that carries valid data. A narrow store therefore reaches memory as a single write cycle, with no read-modify-write.

On a load it takes the addressed byte or half-word out of the 32-bit word the bus returns and moves it to the low bits of the result. The bits above it are filled with zeros for an unsigned load, or with copies of the value's top bit for a signed load. A word or half-word request that is not aligned to its natural boundary is rejected with an error pulse and never reaches the bus.

Toward the bus, a registered request/acknowledge handshake holds every bus field stable from the start of a cycle until the cycle is acknowledged.

Top module: `lsu_lane_align`

## Requirements
- R1: Lanes are numbered little-endian: lane n is bus data bits [8n+7:8n]. A byte store at address offset n (address bits [1:0]) drives the low byte of the write data on lane n and drives bus_sel_o = 1 << n.
- R2: A half-word store at offset 0 drives write data bits [15:0] on lanes 0 and 1 with bus_sel_o = 4'b0011. At offset 2 it drives the same bits on lanes 2 and 3 with bus_sel_o = 4'b1100.
- R3: A word store at offset 0 drives bus_sel_o = 4'b1111 and passes the write data to bus_dat_o unchanged.
- R4: The size code on size_i is 0 for a byte, 1 for a half-word, 2 for a word and 3 reserved. A half-word at an odd address, a word at a nonzero offset, or size code 3 is rejected. The unit raises err_o for exactly one cycle, in the cycle after the request, and in that case starts no bus cycle and keeps bus_sel_o at zero.
- R5: An unsigned load (sext_i = 0) returns the addressed byte in rdata_o[7:0] with zeros above it, or the addressed half-word (lanes 0-1 at offset 0, lanes 2-3 at offset 2) in rdata_o[15:0] with zeros above it.
- R6: A signed load (sext_i = 1) fills rdata_o above the value with copies of bit 7 for a byte or bit 15 for a half-word. A word load returns bus_dat_i unchanged, whatever sext_i is.
- R7: While bus_cyc_o is high and no acknowledge has arrived, bus_adr_o, bus_dat_o, bus_sel_o and bus_we_o hold their values. bus_adr_o is the request address with bits [1:0] cleared.
- R8: bus_cyc_o rises in the cycle after an accepted request. It falls in the cycle after bus_ack_i is sampled high, and in that same cycle done_o pulses high for one cycle. On a load, rdata_o holds the extracted value from that cycle on.
- R9: While a bus cycle is in progress, req_i is ignored: the bus fields do not change, and the ignored request never produces a cycle of its own.
- R10: bus_sel_o is zero whenever bus_cyc_o is low, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled while the unit is idle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| sext_i | input | 1 | Sign-extend a narrow load |
| addr_i | input | 32 | Byte address |
| wdata_i | input | 32 | Store data, right-justified |
| busy_o | output | 1 | Bus cycle in progress |
| done_o | output | 1 | One-cycle pulse when an access completes |
| err_o | output | 1 | One-cycle pulse when a request is misaligned or illegal |
| rdata_o | output | 32 | Aligned and extended load result |
| bus_cyc_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | Bus write enable |
| bus_adr_o | output | 32 | Word-aligned bus address |
| bus_sel_o | output | 4 | Byte-lane selects |
| bus_dat_o | output | 32 | Lane-positioned write data |
| bus_dat_i | input | 32 | Read data from the bus |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The hardest behaviour to bring about from the ports is a second request that arrives while an earlier bus cycle is still waiting for its acknowledge, because the processor side normally waits for done_o before it asks again. The bench's bus model therefore inserts zero to two wait states, chosen by the sweep indices. In the first wait state of each stalled cycle it pulses req_i with a different address and size, then checks that the bus fields stay as they were and that no extra cycle follows. The sweep covers every combination of size code, offset, direction and signedness, with read data whose lane top bits alternate, so that each extension path sees both a set and a cleared sign bit.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lsu_size_e;
endpackage

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lsu_size_e           size_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [LANES-1:0]    sel_o,
  output logic [DATA_W-1:0]   dat_o,
  output logic                misal_o
);
  // selected lanes carry the value; replicas elsewhere are don't-care
  always_comb begin
    unique case (size_i)
      SZ_BYTE: dat_o = {LANES{wdata_i[7:0]}};
      SZ_HALF: dat_o = {(LANES/2){wdata_i[15:0]}};
      default: dat_o = wdata_i;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misal_o = 1'b0;
      SZ_HALF: misal_o = off_i[0];
      SZ_WORD: misal_o = (off_i != '0);
      default: misal_o = 1'b1;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_sel
    always_comb begin
      unique case (size_i)
        SZ_BYTE: sel_o[l] = (off_i == OFF_W'(l));
        SZ_HALF: sel_o[l] = (off_i[OFF_W-1:1] == (OFF_W-1)'(l / 2));
        SZ_WORD: sel_o[l] = 1'b1;
        default: sel_o[l] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  lsu_size_e          size_i,
  input  logic               sext_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [DATA_W-1:0]  value_o
);
  logic [7:0]  lane  [LANES];
  logic [15:0] halfw [LANES/2];
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane[l] = rdata_i[8*l +: 8];
  end
  for (genvar h = 0; h < LANES / 2; h++) begin : g_half
    assign halfw[h] = rdata_i[16*h +: 16];
  end

  assign byte_v = lane[off_i];
  assign half_v = halfw[off_i[OFF_W-1:1]];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){sext_i & byte_v[7]}}, byte_v};
      SZ_HALF: value_o = {{(DATA_W-16){sext_i & half_v[15]}}, half_v};
      default: value_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_bus_ctrl.sv
module lsu_bus_ctrl
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  lsu_size_e          size_i,
  input  logic               sext_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LANES-1:0]   sel_i,
  input  logic [DATA_W-1:0]  dat_i,
  input  logic               misal_i,
  input  logic               ack_i,
  input  logic [DATA_W-1:0]  load_val_i,
  output logic               cyc_o,
  output logic               we_o,
  output logic [ADDR_W-1:0]  adr_o,
  output logic [LANES-1:0]   sel_o,
  output logic [DATA_W-1:0]  dat_o,
  output lsu_size_e          size_o,
  output logic               sext_o,
  output logic [OFF_W-1:0]   off_o,
  output logic               done_o,
  output logic               err_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic accept;
  assign accept = req_i & ~cyc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o   <= 1'b0;
      we_o    <= 1'b0;
      adr_o   <= '0;
      sel_o   <= '0;
      dat_o   <= '0;
      size_o  <= SZ_BYTE;
      sext_o  <= 1'b0;
      off_o   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (accept) begin
        if (misal_i) begin
          err_o <= 1'b1;
        end else begin
          cyc_o  <= 1'b1;
          we_o   <= we_i;
          adr_o  <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
          sel_o  <= sel_i;
          dat_o  <= dat_i;
          size_o <= size_i;
          sext_o <= sext_i;
          off_o  <= addr_i[OFF_W-1:0];
        end
      end else if (cyc_o && ack_i) begin
        cyc_o  <= 1'b0;
        sel_o  <= '0;
        done_o <= 1'b1;
        if (!we_o) rdata_o <= load_val_i;
      end
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [1:0]         size_i,
  input  logic               sext_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               bus_cyc_o,
  output logic               bus_we_o,
  output logic [ADDR_W-1:0]  bus_adr_o,
  output logic [LANES-1:0]   bus_sel_o,
  output logic [DATA_W-1:0]  bus_dat_o,
  input  logic [DATA_W-1:0]  bus_dat_i,
  input  logic               bus_ack_i
);
  lsu_size_e         req_size, cyc_size;
  logic [LANES-1:0]  pk_sel;
  logic [DATA_W-1:0] pk_dat, ld_val;
  logic              pk_misal, cyc_sext;
  logic [OFF_W-1:0]  cyc_off;

  assign req_size = lsu_size_e'(size_i);

  lane_store_pack #(.DATA_W(DATA_W)) u_pack (
    .size_i  (req_size),
    .off_i   (addr_i[OFF_W-1:0]),
    .wdata_i (wdata_i),
    .sel_o   (pk_sel),
    .dat_o   (pk_dat),
    .misal_o (pk_misal)
  );

  lsu_bus_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .size_i     (req_size),
    .sext_i     (sext_i),
    .addr_i     (addr_i),
    .sel_i      (pk_sel),
    .dat_i      (pk_dat),
    .misal_i    (pk_misal),
    .ack_i      (bus_ack_i),
    .load_val_i (ld_val),
    .cyc_o      (bus_cyc_o),
    .we_o       (bus_we_o),
    .adr_o      (bus_adr_o),
    .sel_o      (bus_sel_o),
    .dat_o      (bus_dat_o),
    .size_o     (cyc_size),
    .sext_o     (cyc_sext),
    .off_o      (cyc_off),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o)
  );

  lane_load_extract #(.DATA_W(DATA_W)) u_extract (
    .size_i  (cyc_size),
    .sext_i  (cyc_sext),
    .off_i   (cyc_off),
    .rdata_i (bus_dat_i),
    .value_o (ld_val)
  );

  assign busy_o = bus_cyc_o;
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               done_o,
  input logic               err_o,
  input logic               bus_cyc_o,
  input logic               bus_we_o,
  input logic [ADDR_W-1:0]  bus_adr_o,
  input logic [LANES-1:0]   bus_sel_o,
  input logic [DATA_W-1:0]  bus_dat_o,
  input logic               bus_ack_i
);
  AST_ERR_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!bus_cyc_o && bus_sel_o == '0)); // R4
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R4
  AST_HOLD_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !bus_ack_i) |=> ($stable(bus_adr_o) && $stable(bus_dat_o)
                                  && $stable(bus_sel_o) && $stable(bus_we_o) && bus_cyc_o)); // R7
  AST_ADR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> (bus_adr_o[1:0] == 2'b00)); // R7
  AST_SEL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> ($countones(bus_sel_o) inside {1, 2, LANES})); // R1
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && bus_ack_i) |=> (done_o && !bus_cyc_o)); // R8
  AST_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_cyc_o |-> (bus_sel_o == '0)); // R10
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .done_o    (done_o),
  .err_o     (err_o),
  .bus_cyc_o (bus_cyc_o),
  .bus_we_o  (bus_we_o),
  .bus_adr_o (bus_adr_o),
  .bus_sel_o (bus_sel_o),
  .bus_dat_o (bus_dat_o),
  .bus_ack_i (bus_ack_i)
);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, sext_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] rdata_o;
  logic        bus_cyc_o, bus_we_o;
  logic [31:0] bus_adr_o, bus_dat_o;
  logic [3:0]  bus_sel_o;
  logic [31:0] bus_dat_i = '0;
  logic        bus_ack_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  lsu_lane_align u_lsu_lane_align (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (act=%0d exp<150000)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pat_w(input int p);
    case (p)
      0: return 32'h1357_9BDF;
      1: return 32'hA5C3_F08E;
      default: return 32'h7E81_24B6;
    endcase
  endfunction

  function automatic logic [31:0] pat_r(input int p);
    case (p)
      0: return 32'h80FF_7F01;
      1: return 32'h7F00_80FE;
      default: return 32'hC3A5_5A3C;
    endcase
  endfunction

  task automatic access(input bit we, input int sz, input bit sx, input int off,
                        input logic [31:0] wd, input logic [31:0] rd, input int waits);
    logic [31:0] a;
    bit          bad;
    logic [3:0]  esel;
    logic [31:0] v, eres;
    string       tag;
    a   = 32'h0000_4A30 + 32'(off);
    bad = (sz == 3) || (sz == 2 && off != 0) || (sz == 1 && (off % 2) != 0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; size_i = 2'(sz); sext_i = sx; addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    if (bad) begin
      chk(err_o == 1'b1, "R4 err pulse", 32'(err_o), 32'd1);
      chk(bus_cyc_o == 1'b0 && bus_sel_o == 4'd0, "R4 no cycle", {bus_sel_o, 27'd0, bus_cyc_o}, 32'd0);
      @(negedge clk_i);
      chk(err_o == 1'b0 && bus_cyc_o == 1'b0, "R4 err single", {30'd0, err_o, bus_cyc_o}, 32'd0);
      return;
    end
    tag = (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
    esel = (sz == 0) ? 4'(1 << off) : (sz == 1) ? ((off == 0) ? 4'b0011 : 4'b1100) : 4'b1111;
    chk(err_o == 1'b0, "R4 no err on aligned", 32'(err_o), 32'd0);
    chk(bus_cyc_o == 1'b1 && bus_we_o == we, "R8 cycle start", {30'd0, bus_we_o, bus_cyc_o}, {30'd0, we, 1'b1});
    chk(bus_adr_o == (a & ~32'd3), "R7 address", bus_adr_o, a & ~32'd3);
    chk(bus_sel_o == esel, {tag, " select"}, 32'(bus_sel_o), 32'(esel));
    if (we) begin
      if (sz == 0)
        chk(((bus_dat_o >> (8*off)) & 32'hFF) == (wd & 32'hFF), "R1 lane data",
            (bus_dat_o >> (8*off)) & 32'hFF, wd & 32'hFF);
      else if (sz == 1)
        chk(((bus_dat_o >> (8*off)) & 32'hFFFF) == (wd & 32'hFFFF), "R2 lane data",
            (bus_dat_o >> (8*off)) & 32'hFFFF, wd & 32'hFFFF);
      else
        chk(bus_dat_o == wd, "R3 word data", bus_dat_o, wd);
    end
    if (waits > 0) begin
      // stray request while busy
      req_i = 1'b1; addr_i = 32'h0000_0F04; size_i = 2'd2; we_i = ~we;
      @(negedge clk_i);
      req_i = 1'b0;
      chk(bus_adr_o == (a & ~32'd3) && bus_sel_o == esel && bus_we_o == we && bus_cyc_o,
          "R9 busy request ignored", bus_adr_o, a & ~32'd3);
      for (int w = 1; w < waits; w++) begin
        @(negedge clk_i);
        chk(bus_adr_o == (a & ~32'd3) && bus_sel_o == esel && bus_cyc_o, "R7 held",
            {bus_adr_o[31:4], bus_sel_o}, {a[31:4], esel});
      end
    end
    bus_ack_i = 1'b1; bus_dat_i = rd;
    @(negedge clk_i);
    bus_ack_i = 1'b0;
    chk(bus_cyc_o == 1'b0 && done_o == 1'b1, "R8 end with done", {30'd0, done_o, bus_cyc_o}, 32'd2);
    chk(bus_sel_o == 4'd0, "R10 select idle", 32'(bus_sel_o), 32'd0);
    if (!we) begin
      if (sz == 0) begin
        v = (rd >> (8*off)) & 32'hFF;
        eres = (sx && v[7]) ? (v | 32'hFFFF_FF00) : v;
      end else if (sz == 1) begin
        v = (rd >> (8*off)) & 32'hFFFF;
        eres = (sx && v[15]) ? (v | 32'hFFFF_0000) : v;
      end else begin
        eres = rd;
      end
      chk(rdata_o == eres, (sz == 2) ? "R6 word load" : (sx ? "R6 signed load" : "R5 unsigned load"),
          rdata_o, eres);
    end
    @(negedge clk_i);
    chk(done_o == 1'b0 && bus_cyc_o == 1'b0, "R9 no extra cycle", {30'd0, done_o, bus_cyc_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(bus_cyc_o == 1'b0 && bus_sel_o == 4'd0, "R10 reset idle", {bus_sel_o, 27'd0, bus_cyc_o}, 32'd0);
    chk(done_o == 1'b0 && err_o == 1'b0 && rdata_o == 32'd0, "R8 reset state", rdata_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int we = 0; we < 2; we++)
      for (int sz = 0; sz < 4; sz++)
        for (int sx = 0; sx < 2; sx++)
          for (int off = 0; off < 4; off++)
            for (int p = 0; p < 3; p++)
              access(we[0], sz, sx[0], off, pat_w(p) ^ 32'(off * 32'h0101_0101),
                     pat_r(p) ^ 32'(sx * 32'h1010_0000), (off + p) % 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule